// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritizer

This block turns the status conditions of a UART into a single interrupt request line and an identification byte that the host reads to learn which condition needs attention. Five sources compete: receiver line errors, a receive character timeout, received data available, transmit holding register empty, and modem status change. Only the most urgent enabled source is reported. The FIFO storage, the shifter and the baud logic sit elsewhere and feed the block plain status flags.

The block owns the interrupt enable register and the pending latch for the transmit-empty source. That latch is armed when the holding register drains, or when the host turns its enable on while the holding register is already empty. It is cleared when the host writes a transmit byte, turns the enable off, or reads the identification byte while it reports transmit-empty. The identification byte and the interrupt line are combinational functions of the registered enable and latch and of the incoming status flags.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the enable readback is 0x00, the identification byte is 0x01 and the interrupt line is low.
- R2: Sources are ranked line status, then timeout, then data available, then transmit empty, then modem status. The identification bits 3:0 give the code of the highest enabled active source: 0x6, 0xC, 0x4, 0x2, 0x0, or 0x1 when none is active.
- R3: The line status source is active when enable bit 2 is set and any of the four error inputs (overrun, parity, framing, break) is set.
- R4: The timeout source is active when the timeout flag is set and enable bit 0 (the data-available enable) is set; it has no enable of its own.
- R5: The data-available source needs enable bit 0 and the data-ready flag. With FIFOs on it also needs the receive count to be at or above the trigger level; with FIFOs off data-ready suffices.
- R6: An enable write stores data bits 3:0 (bit 0 data/timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status); bits 7:4 always read back as zero.
- R7: An enable write that turns bit 1 on arms the transmit-empty latch when the holding register is empty and leaves it clear otherwise; an enable write that leaves bit 1 unchanged does not re-arm it.
- R8: A read of the identification byte that returns code 0x2 clears the transmit-empty latch; a read returning any other code leaves it intact.
- R9: A transmit byte write clears the transmit-empty latch.
- R10: A rising edge of the holding-register-empty flag arms the transmit-empty latch.
- R11: Identification bits 7:6 read 11 when FIFOs are on and 00 when off, bits 5:4 read zero, and the interrupt line is high exactly when the code is not 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| iir_rd | input | 1 | Identification byte read strobe |
| thr_wr | input | 1 | Transmit byte write strobe |
| fifo_en | input | 1 | FIFOs enabled |
| line_err | input | 4 | Overrun, parity, framing, break flags |
| data_ready | input | 1 | Receive data ready flag |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level |
| rx_timeout | input | 1 | Character timeout pending flag |
| thr_empty | input | 1 | Holding register empty flag |
| msr_delta | input | 4 | Modem status change flags |
| ier_q | output | 8 | Enable register readback |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
A sweep walks all sixteen enable values against every on/off mix of the five sources, with FIFOs on and off and the receive count placed exactly at the trigger level or one below it; this separates the priority ranking from the masking of each source and shows that the timeout follows the data enable. Because the sweep arms the transmit latch through enable writes with the holding register empty or not, it also separates the arming rule from the static mask. Directed sequences then exercise the latch life cycle: arming on a drain edge, clearing by a read that reports transmit-empty, survival through a read that reports a higher source, no re-arm on a write that leaves the enable unchanged, and clearing by a transmit write.

// File: rtl/uart_irq_pkg.sv
// Shared codes and source indices for the UART interrupt prioritizer.
// Assumes the identification code occupies four bits.
package uart_irq_pkg;

    localparam int NUM_SRC = 5;

    // Source index: lower index means higher priority.
    localparam int SRC_LINE  = 0;
    localparam int SRC_TMO   = 1;
    localparam int SRC_RXD   = 2;
    localparam int SRC_THRE  = 3;
    localparam int SRC_MODEM = 4;

    typedef enum logic [3:0] {
        IID_MODEM = 4'h0,
        IID_NONE  = 4'h1,
        IID_THRE  = 4'h2,
        IID_RXD   = 4'h4,
        IID_LINE  = 4'h6,
        IID_TMO   = 4'hC
    } iid_e;

    // Enable bit positions.
    localparam int EN_RXD   = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    function automatic iid_e src_code(input int idx);
        case (idx)
            SRC_LINE:  return IID_LINE;
            SRC_TMO:   return IID_TMO;
            SRC_RXD:   return IID_RXD;
            SRC_THRE:  return IID_THRE;
            default:   return IID_MODEM;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_ctl.sv
// Holds the interrupt enable register and the transmit-empty pending latch.
// Assumes strobes are single-cycle; on coincident events a transmit write
// wins, then an enable write that changes bit 1, then a clearing read,
// then a drain edge of the holding register.
module uart_irq_ctl
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ier_wr,
    input  logic [3:0] ier_wdata,
    input  logic       iir_rd,
    input  logic       code_is_thre,
    input  logic       thr_wr,
    input  logic       thr_empty,
    output logic [3:0] ier_r,
    output logic       thre_pend
);

    logic thr_empty_d;
    logic bit1_toggle;

    assign bit1_toggle = ier_wr && (ier_wdata[EN_THRE] != ier_r[EN_THRE]);

    // Enable register load.
    always_ff @(posedge clk) begin
        if (!rst_n)       ier_r <= '0;
        else if (ier_wr)  ier_r <= ier_wdata;
    end

    // Delayed empty flag; resets high so reset itself is not a drain edge.
    always_ff @(posedge clk) begin
        if (!rst_n) thr_empty_d <= 1'b1;
        else        thr_empty_d <= thr_empty;
    end

    // Transmit-empty pending latch set and clear rules.
    always_ff @(posedge clk) begin
        if (!rst_n)                       thre_pend <= 1'b0;
        else if (thr_wr)                  thre_pend <= 1'b0;
        else if (bit1_toggle)             thre_pend <= ier_wdata[EN_THRE] & thr_empty;
        else if (iir_rd && code_is_thre)  thre_pend <= 1'b0;
        else if (thr_empty && !thr_empty_d) thre_pend <= 1'b1;
    end

endmodule

// File: rtl/uart_irq_srcs.sv
// Forms the five masked interrupt requests from enables and status flags.
// Assumes rx_count and rx_trig share a width; purely combinational.
module uart_irq_srcs
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       ier_r,
    input  logic             thre_pend,
    input  logic             fifo_en,
    input  logic [3:0]       line_err,
    input  logic             data_ready,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic [3:0]       msr_delta,
    output logic [NUM_SRC-1:0] req
);

    logic level_met;

    // Threshold test only matters with FIFOs on.
    always_comb level_met = !fifo_en || (rx_count >= rx_trig);

    // Masked request per source, indexed by priority.
    always_comb begin
        req            = '0;
        req[SRC_LINE]  = ier_r[EN_LINE]  && (|line_err);
        req[SRC_TMO]   = ier_r[EN_RXD]   && rx_timeout;
        req[SRC_RXD]   = ier_r[EN_RXD]   && data_ready && level_met;
        req[SRC_THRE]  = ier_r[EN_THRE]  && thre_pend;
        req[SRC_MODEM] = ier_r[EN_MODEM] && (|msr_delta);
    end

endmodule

// File: rtl/uart_irq_enc.sv
// Priority encoder: picks the lowest-index active request and emits its code.
// Assumes index 0 is the most urgent source.
module uart_irq_enc
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output logic [3:0]         code
);

    // Scan from least to most urgent so the most urgent assignment lands last.
    always_comb begin
        code = IID_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) code = src_code(i);
        end
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Top of the UART interrupt prioritizer: enable register, transmit-empty
// latch, source masking and priority encoding. Identification byte and
// interrupt line are combinational from registered state and status inputs.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [7:0]       ier_wdata,
    input  logic             iir_rd,
    input  logic             thr_wr,
    input  logic             fifo_en,
    input  logic [3:0]       line_err,
    input  logic             data_ready,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic             thr_empty,
    input  logic [3:0]       msr_delta,
    output logic [7:0]       ier_q,
    output logic [7:0]       iir_q,
    output logic             irq
);

    logic [3:0]         ier_r;
    logic               thre_pend;
    logic [NUM_SRC-1:0] req;
    logic [3:0]         code;
    logic               code_is_thre;

    assign code_is_thre = (code == IID_THRE);

    uart_irq_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ier_wr       (ier_wr),
        .ier_wdata    (ier_wdata[3:0]),
        .iir_rd       (iir_rd),
        .code_is_thre (code_is_thre),
        .thr_wr       (thr_wr),
        .thr_empty    (thr_empty),
        .ier_r        (ier_r),
        .thre_pend    (thre_pend)
    );

    uart_irq_srcs #(.CNT_W(CNT_W)) u_srcs (
        .ier_r      (ier_r),
        .thre_pend  (thre_pend),
        .fifo_en    (fifo_en),
        .line_err   (line_err),
        .data_ready (data_ready),
        .rx_count   (rx_count),
        .rx_trig    (rx_trig),
        .rx_timeout (rx_timeout),
        .msr_delta  (msr_delta),
        .req        (req)
    );

    uart_irq_enc u_enc (
        .req  (req),
        .code (code)
    );

    // Output assembly: FIFO marker, zero pad, code; upper enable bits zero.
    always_comb begin
        ier_q = {4'b0000, ier_r};
        iir_q = {{2{fifo_en}}, 2'b00, code};
        irq   = (code != IID_NONE);
    end

endmodule

// File: rtl/uart_irq_chk.sv
// Checker for the UART interrupt prioritizer, attached by bind.
// Observes ports only; all properties are disabled during reset.
module uart_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_wr,
    input logic [7:0] ier_wdata,
    input logic       iir_rd,
    input logic       thr_wr,
    input logic [3:0] line_err,
    input logic       thr_empty,
    input logic [7:0] ier_q,
    input logic [7:0] iir_q,
    input logic       irq
);

    // R9: a transmit write leaves no transmit-empty code next cycle.
    p_thrwr_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (iir_q[3:0] != 4'h2));

    // R8: a read reporting transmit-empty retires it.
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_q[3:0] == 4'h2 && !ier_wr) |=> (iir_q[3:0] != 4'h2));

    // R6: enable writes load the low nibble.
    p_ier_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> (ier_q[3:0] == $past(ier_wdata[3:0])));

    // R3: enabled line errors always win.
    p_line_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[2] && (|line_err)) |-> (iir_q[3:0] == 4'h6 && irq));

    // R7: turning the enable on with an empty holding register raises a request.
    p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && ier_wdata[1] && !ier_q[1] && thr_empty && !thr_wr) |=> irq);

    // R11: the request line follows the code.
    p_irq_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_q[3:0] != 4'h1));

endmodule

bind uart_irq_prio uart_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier_wr    (ier_wr),
    .ier_wdata (ier_wdata),
    .iir_rd    (iir_rd),
    .thr_wr    (thr_wr),
    .line_err  (line_err),
    .thr_empty (thr_empty),
    .ier_q     (ier_q),
    .iir_q     (iir_q),
    .irq       (irq)
);

// File: tb/tb_uart_irq_prio.sv
// Bench: exhaustive source/enable sweep plus directed latch sequences.
module tb_uart_irq_prio;

    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ier_wr = 1'b0;
    logic [7:0]       ier_wdata = '0;
    logic             iir_rd = 1'b0;
    logic             thr_wr = 1'b0;
    logic             fifo_en = 1'b0;
    logic [3:0]       line_err = '0;
    logic             data_ready = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] rx_trig = 5'd1;
    logic             rx_timeout = 1'b0;
    logic             thr_empty = 1'b0;
    logic [3:0]       msr_delta = '0;
    logic [7:0]       ier_q;
    logic [7:0]       iir_q;
    logic             irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    uart_irq_prio #(.FIFO_DEPTH(16)) dut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .iir_rd(iir_rd), .thr_wr(thr_wr), .fifo_en(fifo_en),
        .line_err(line_err), .data_ready(data_ready), .rx_count(rx_count),
        .rx_trig(rx_trig), .rx_timeout(rx_timeout), .thr_empty(thr_empty),
        .msr_delta(msr_delta), .ier_q(ier_q), .iir_q(iir_q), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Reference ranking from the requirements (R2..R5).
    function automatic logic [3:0] model_code(input logic [3:0] en, input logic [3:0] err,
            input logic tmo, input logic dr, input logic fifo, input int cnt, input int trig,
            input logic pend, input logic [3:0] dlt);
        if (en[2] && err != 0)                         return 4'h6;
        if (en[0] && tmo)                              return 4'hC;
        if (en[0] && dr && (!fifo || cnt >= trig))     return 4'h4;
        if (en[1] && pend)                             return 4'h2;
        if (en[3] && dlt != 0)                         return 4'h0;
        return 4'h1;
    endfunction

    task automatic wr_ier(input logic [7:0] v);
        @(negedge clk); ier_wr = 1'b1; ier_wdata = v;
        @(negedge clk); ier_wr = 1'b0;
    endtask

    task automatic rd_iir();
        @(negedge clk); iir_rd = 1'b1;
        @(negedge clk); iir_rd = 1'b0;
    endtask

    task automatic wr_thr();
        @(negedge clk); thr_wr = 1'b1;
        @(negedge clk); thr_wr = 1'b0;
    endtask

    task automatic settle();
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1: reset state.
        chk("R1 ier", ier_q, 8'h00);
        chk("R1 iir", iir_q, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R6: upper enable bits read zero.
        wr_ier(8'hF5); settle();
        chk("R6 readback", ier_q, 8'h05);

        // Sweep: R2 R3 R4 R5 R7 R11.
        for (int idx = 0; idx < 1024; idx++) begin
            logic [3:0] en;
            logic [3:0] err;
            logic       te;
            int         trig;
            int         cnt;
            logic [3:0] exp_code;
            en   = idx[3:0];
            trig = (idx[3:2] == 0) ? 1 : (idx[3:2] == 1) ? 4 : (idx[3:2] == 2) ? 8 : 14;
            cnt  = idx[8] ? trig : trig - 1;
            err  = idx[4] ? (4'b0001 << idx[2:1]) : 4'b0000;
            te   = idx[1] ^ idx[5] ^ idx[9];
            @(negedge clk);
            line_err   = err;
            rx_timeout = idx[5];
            data_ready = idx[6];
            fifo_en    = idx[7];
            rx_trig    = CNT_W'(trig);
            rx_count   = CNT_W'(cnt);
            msr_delta  = idx[9] ? (4'b0001 << idx[5:4]) : 4'b0000;
            thr_empty  = te;
            @(negedge clk);
            wr_ier(8'h00);
            wr_ier({4'hA, en});
            settle();
            exp_code = model_code(en, err, idx[5], idx[6], idx[7], cnt, trig,
                                  en[1] & te, msr_delta);
            chk($sformatf("R2 R3 R4 R5 R7 code idx=%0d", idx), {4'h0, iir_q[3:0]}, {4'h0, exp_code});
            chk($sformatf("R11 byte idx=%0d", idx), iir_q,
                {{2{idx[7]}}, 2'b00, exp_code});
            chk($sformatf("R11 irq idx=%0d", idx), {7'd0, irq}, {7'd0, exp_code != 4'h1});
        end

        // Directed latch sequences.
        @(negedge clk);
        line_err = 0; rx_timeout = 0; data_ready = 0; fifo_en = 0; msr_delta = 0;
        thr_empty = 1'b0;
        @(negedge clk);
        wr_ier(8'h00);
        wr_ier(8'h02); settle();
        chk("R7 no arm when busy", iir_q, 8'h01);
        @(negedge clk); thr_empty = 1'b1;
        @(negedge clk); settle();
        chk("R10 drain edge arms", iir_q, 8'h02);
        rd_iir(); settle();
        chk("R8 read clears", iir_q, 8'h01);
        wr_ier(8'h03); settle();
        chk("R7 unchanged bit no re-arm", iir_q, 8'h01);

        wr_ier(8'h00);
        wr_ier(8'h06); settle();
        chk("R7 arm when empty", iir_q, 8'h02);
        @(negedge clk); line_err = 4'b1000;
        @(negedge clk); settle();
        chk("R3 break outranks", iir_q, 8'h06);
        rd_iir();
        @(negedge clk); line_err = 4'b0000;
        @(negedge clk); settle();
        chk("R8 other-code read keeps latch", iir_q, 8'h02);
        wr_thr(); settle();
        chk("R9 transmit write clears", iir_q, 8'h01);

        // R5 boundary with FIFO on: one below trigger, then at trigger.
        wr_ier(8'h01);
        @(negedge clk); fifo_en = 1'b1; data_ready = 1'b1; rx_trig = 5'd14; rx_count = 5'd13;
        settle();
        chk("R5 below trigger", iir_q, 8'hC1);
        @(negedge clk); rx_count = 5'd14; settle();
        chk("R5 at trigger", iir_q, 8'hC4);
        // R4: timeout masked when data enable off.
        @(negedge clk); data_ready = 1'b0; rx_timeout = 1'b1; settle();
        chk("R4 timeout enabled", iir_q, 8'hC0 | 8'h0C);
        wr_ier(8'h08); settle();
        chk("R4 timeout masked", iir_q, 8'hC1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule